// File: doc/BRIEF.md
# Dual-Modulus Programmable Frequency Divider

This block divides a fast oscillator clock by an unsigned binary divide code, for use as the feedback divider of a frequency synthesizer loop. The division is built from a prescaler that counts either P−1 or P input clocks per cycle (P = 2^PRE_W, 32 by default), steered by a main counter and a swallow counter. A code N is split into a main count M = ceil(N/P) and a swallow count A = P·M − N. The first A prescaler cycles of each output period are short (P−1 clocks) and the remaining M − A are full (P clocks), which adds up to N input clocks.

The output `div_o` drops at the start of the last prescaler cycle of each period and rises when the counters reload, so a falling-edge phase detector sees one edge every N clocks. A new code is captured on a load strobe and used from the next reload on, so a period that is running is never cut short. A clear input makes the current prescaler cycle the last one, so the counters reload at its end. Codes that this structure cannot reach are flagged and still divided, with the counts clamped. With the default parameters every code from 961 to 16383 divides exactly.

Top module: `ndiv_dualmod`

## Requirements
- R1: While `rst_ni` is low, `div_o` and `invalid_o` are both low.
- R2: For a code N with M = ceil(N/P) ≥ 2 and A = P·M − N ≤ M, successive rising edges of `div_o`, and successive falling edges, are exactly N input clocks apart.
- R3: For any other code (M < 2 or A > M) the period is P·M' − min(A', M') clocks, where M' = max(M, 2) and A' = P·M' − N; code 0 falls in this case.
- R4: `div_o` is low for exactly one prescaler cycle at the end of each period: P−1 clocks when the clamped swallow count equals the clamped main count, P clocks otherwise.
- R5: A code presented with `load_i` high is captured at that clock edge and takes effect at the next reload (the edge where `div_o` rises); the period already running keeps its length.
- R6: When `load_i` is high at the very clock edge where the counters reload, the new code already governs the period that begins at that edge.
- R7: `clear_i` high at an edge while `div_o` is high drives `div_o` low after that edge, and the counters reload at the end of the current prescaler cycle; `clear_i` while `div_o` is already low does not change the length of that low phase.
- R8: `invalid_o` is updated at each reload and is high for the whole of a period whose code falls under R3, low for a period whose code falls under R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_i | input | CODE_W | Unsigned divide code |
| load_i | input | 1 | Capture strobe for `code_i` |
| clear_i | input | 1 | Forces a reload at the end of the current prescaler cycle |
| div_o | output | 1 | Divided output, low during the last prescaler cycle of a period |
| invalid_o | output | 1 | The running period uses a code outside the exactly reachable set |

## Verification
The two functions that can meet in one clock are the capture of a new code and the reload of the counters, and likewise a clear and a reload. The bench provokes the first by counting the low phase of `div_o` from its known length and raising `load_i` for exactly the edge at which `div_o` rises, then judging the following period against the new code rather than the old one; a load one clock later is checked to leave the running period untouched. Clear is applied both in the high phase and inside the low phase, and the low-phase length and the next period are compared with values computed from M and A.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;

  // Modulus choice handed from the count controller to the prescaler.
  typedef enum logic {
    PMOD_FULL  = 1'b0,  // prescaler cycle of P input clocks
    PMOD_SHORT = 1'b1   // prescaler cycle of P-1 input clocks
  } pmod_e;

endpackage

// File: rtl/ndiv_split.sv
module ndiv_split #(
  parameter int CODE_W = 14,
  parameter int PRE_W  = 5,
  localparam int MW    = CODE_W - PRE_W + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [MW-1:0]     main_o,
  output logic [MW-1:0]     swal_o,
  output logic              bad_o
);

  localparam int P  = 1 << PRE_W;
  localparam int XW = CODE_W + 2;

  logic [XW-1:0] n_x;
  logic [XW-1:0] m_raw;
  logic [XW-1:0] m_eff;
  logic [XW-1:0] prod;
  logic [XW-1:0] a_raw;
  logic [XW-1:0] a_eff;
  logic          m_short;
  logic          a_over;

  // M = ceil(N/P), at least 2; A = P*M - N, at most M.
  always_comb begin
    n_x     = XW'(code_i);
    m_raw   = (n_x + XW'(P - 1)) >> PRE_W;
    m_short = (m_raw < XW'(2));
    m_eff   = m_short ? XW'(2) : m_raw;
    prod    = m_eff << PRE_W;
    a_raw   = prod - n_x;
    a_over  = (a_raw > m_eff);
    a_eff   = a_over ? m_eff : a_raw;
  end

  assign main_o = m_eff[MW-1:0];
  assign swal_o = a_eff[MW-1:0];
  assign bad_o  = m_short | a_over;

  // R2: a code reported reachable rebuilds exactly from its two counts.
  always_comb begin
    if (!$isunknown(code_i) && !bad_o) begin
      a_exact_r2 : assert ((XW'(main_o) << PRE_W) - XW'(swal_o) == XW'(code_i));
    end
  end

endmodule

// File: rtl/ndiv_prescaler.sv
module ndiv_prescaler
  import ndiv_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pmod_e sel_i,
  output logic  tc_o
);

  localparam int P = 1 << PRE_W;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic [PRE_W-1:0] last_val;
  logic             cnt_en;

  assign cnt_en   = 1'b1;
  assign last_val = (sel_i == PMOD_SHORT) ? PRE_W'(P - 2) : PRE_W'(P - 1);
  assign tc_o     = (cnt_q == last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      cnt_d = tc_o ? '0 : cnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R4: a short prescaler cycle never reaches the full-cycle last count.
  p_short_range_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == PMOD_SHORT) |-> (cnt_q <= PRE_W'(P - 2)));

  // R4: after a terminal count the prescaler restarts from zero.
  p_restart_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> (cnt_q == '0));

endmodule

// File: rtl/ndiv_ctrl.sv
module ndiv_ctrl
  import ndiv_pkg::*;
#(
  parameter int MW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pre_tc_i,
  input  logic          clear_i,
  input  logic [MW-1:0] ld_main_i,
  input  logic [MW-1:0] ld_swal_i,
  input  logic          ld_bad_i,
  output pmod_e         sel_o,
  output logic          reload_o,
  output logic          div_o,
  output logic          bad_o
);

  logic [MW-1:0] m_q, m_d;
  logic [MW-1:0] a_q, a_d;
  logic          div_q, div_d;
  logic          bad_q, bad_d;
  logic          last;

  assign last     = (m_q == MW'(1));
  assign reload_o = pre_tc_i & last;
  assign sel_o    = (a_q != '0) ? PMOD_SHORT : PMOD_FULL;

  always_comb begin
    m_d   = m_q;
    a_d   = a_q;
    bad_d = bad_q;
    if (reload_o) begin
      m_d   = ld_main_i;
      a_d   = ld_swal_i;
      bad_d = ld_bad_i;
    end else begin
      if (pre_tc_i) begin
        m_d = m_q - MW'(1);
        if (a_q != '0) begin
          a_d = a_q - MW'(1);
        end
      end
      if (clear_i) begin
        m_d = MW'(1);
      end
    end
    div_d = (m_d != MW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q   <= MW'(1);
      a_q   <= '0;
      div_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      m_q   <= m_d;
      a_q   <= a_d;
      div_q <= div_d;
      bad_q <= bad_d;
    end
  end

  assign div_o = div_q;
  assign bad_o = bad_q;

  // R2: a reload always starts a high phase.
  p_reload_high_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> div_q);

  // R4: the output only rises on a reload of the counters.
  p_rise_on_reload_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_q) |-> $past(reload_o));

  // R7: clear outside a reload pulls the output low next cycle.
  p_clear_low_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !reload_o) |=> !div_q);

  // R2: the main count never runs out below one.
  p_main_live_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_q != '0);

endmodule

// File: rtl/ndiv_dualmod.sv
module ndiv_dualmod
  import ndiv_pkg::*;
#(
  parameter int CODE_W = 14,
  parameter int PRE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              load_i,
  input  logic              clear_i,
  output logic              div_o,
  output logic              invalid_o
);

  localparam int MW = CODE_W - PRE_W + 1;

  // Reset synchronizer: asserts at once, releases on the clock.
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_n = rs_q[1];

  // Pending code register with bypass for a load in the reload cycle.
  logic [CODE_W-1:0] pend_q, pend_d;
  logic [CODE_W-1:0] src_code;

  always_comb begin
    pend_d = pend_q;
    if (load_i) begin
      pend_d = code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign src_code = load_i ? code_i : pend_q;

  logic [MW-1:0] ld_main;
  logic [MW-1:0] ld_swal;
  logic          ld_bad;
  pmod_e         sel;
  logic          pre_tc;
  logic          reload;

  ndiv_split #(
    .CODE_W (CODE_W),
    .PRE_W  (PRE_W)
  ) u_split (
    .code_i (src_code),
    .main_o (ld_main),
    .swal_o (ld_swal),
    .bad_o  (ld_bad)
  );

  ndiv_prescaler #(
    .PRE_W (PRE_W)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .sel_i  (sel),
    .tc_o   (pre_tc)
  );

  ndiv_ctrl #(
    .MW (MW)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .pre_tc_i  (pre_tc),
    .clear_i   (clear_i),
    .ld_main_i (ld_main),
    .ld_swal_i (ld_swal),
    .ld_bad_i  (ld_bad),
    .sel_o     (sel),
    .reload_o  (reload),
    .div_o     (div_o),
    .bad_o     (invalid_o)
  );

  // R8: the flag only moves on a reload.
  p_flag_moves_r8 : assert property (@(posedge clk_i) disable iff (!rst_n)
    !reload |=> $stable(invalid_o));

  // R5: without a reload the divided output never rises.
  p_no_rise_r5 : assert property (@(posedge clk_i) disable iff (!rst_n)
    (!reload && !div_o) |=> !div_o);

endmodule

// File: tb/sim_ndiv_dualmod.sv
module sim_ndiv_dualmod;

  localparam int CW = 6;
  localparam int PW = 2;
  localparam int P  = 1 << PW;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [CW-1:0] code_i;
  logic          load_i;
  logic          clear_i;
  logic          div_o;
  logic          invalid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  ndiv_dualmod #(.CODE_W(CW), .PRE_W(PW)) u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (code_i),
    .load_i    (load_i),
    .clear_i   (clear_i),
    .div_o     (div_o),
    .invalid_o (invalid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk_i);
  endtask

  task automatic model(input int n, output int per, output int low, output bit inv);
    int m;
    int a;
    m   = (n + P - 1) / P;
    inv = 1'b0;
    if (m < 2) begin
      m   = 2;
      inv = 1'b1;
    end
    a = P * m - n;
    if (a > m) begin
      a   = m;
      inv = 1'b1;
    end
    per = P * m - a;
    low = (a == m) ? P - 1 : P;
  endtask

  task automatic wait_rise;
    logic prev;
    do begin
      prev = div_o;
      tick();
    end while (!(!prev && div_o));
  endtask

  // Called on the first high sample; returns on the next first high sample.
  task automatic measure(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (div_o) begin
      hi++;
      tick();
    end
    while (!div_o) begin
      lo++;
      tick();
    end
  endtask

  task automatic load_code(input int n);
    code_i = CW'(n);
    load_i = 1'b1;
    tick();
    load_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int per, low, hi, lo;
    bit inv;
    int per2, low2;
    bit inv2;

    rst_ni  = 1'b0;
    code_i  = '0;
    load_i  = 1'b0;
    clear_i = 1'b0;
    repeat (3) tick();
    chk(div_o == 1'b0, "R1 div_o in reset", int'(div_o), 0);
    chk(invalid_o == 1'b0, "R1 invalid_o in reset", int'(invalid_o), 0);
    rst_ni = 1'b1;
    repeat (4) tick();

    // Sweep every code of the small configuration.
    for (int n = 0; n < (1 << CW); n++) begin
      model(n, per, low, inv);
      load_code(n);
      wait_rise();
      chk(invalid_o == inv, inv ? "R8 flag set (R3 code)" : "R8 flag clear (R2 code)",
          int'(invalid_o), int'(inv));
      for (int k = 0; k < 2; k++) begin
        measure(hi, lo);
        chk(hi + lo == per, inv ? "R3 clamped period" : "R2 exact period", hi + lo, per);
        chk(lo == low, "R4 low phase length", lo, low);
      end
    end

    // R5: load during a running period leaves it alone.
    load_code(13);
    wait_rise();
    model(13, per, low, inv);
    model(30, per2, low2, inv2);
    tick();
    code_i = CW'(30);
    load_i = 1'b1;
    tick();
    load_i = 1'b0;
    measure(hi, lo);
    chk(hi + lo + 2 == per, "R5 running period kept", hi + lo + 2, per);
    measure(hi, lo);
    chk(hi + lo == per2, "R5 new code next period", hi + lo, per2);

    // R6: load exactly at the reload edge.
    model(22, per, low, inv);
    while (div_o) tick();
    for (int i = 1; i < low2; i++) tick();
    code_i = CW'(22);
    load_i = 1'b1;
    tick();
    load_i = 1'b0;
    chk(div_o == 1'b1, "R6 reload edge aligned", int'(div_o), 1);
    measure(hi, lo);
    chk(hi + lo == per, "R6 same-edge load applies", hi + lo, per);

    // R7: clear in the high phase.
    tick();
    tick();
    clear_i = 1'b1;
    tick();
    clear_i = 1'b0;
    chk(div_o == 1'b0, "R7 clear pulls low", int'(div_o), 0);
    while (!div_o) tick();
    measure(hi, lo);
    chk(hi + lo == per, "R7 period after clear", hi + lo, per);

    // R7: clear inside the low phase changes nothing.
    while (div_o) tick();
    clear_i = 1'b1;
    tick();
    clear_i = 1'b0;
    lo = 1;
    while (!div_o) begin
      lo++;
      tick();
    end
    chk(lo == low, "R7 low phase unchanged by clear", lo, low);
    measure(hi, lo);
    chk(hi + lo == per, "R7 period after low clear", hi + lo, per);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule